// File: doc/BRIEF.md
# Data-dependent vector length truncation sequencer

This block walks the elements of a vector compare-immediate. After a start pulse it steps an element index from zero towards the requested vector length. Each step reads one source register through a read port. It compares the value, as a signed number, against a sign-extended 16-bit immediate. It then emits a 3-bit condition to a condition-field slot. The source and destination slots move forward by one per element only when the operand is flagged as vectorised. A scalar operand stays on its base slot.

Each new condition is tested at once against a chosen bit and sense. The first element that fails the test ends the loop and shortens the vector length. In inclusive mode the failing element is kept. In exclusive mode it is dropped, so the length can fall to zero. The result is presented on `vl_out` together with a one-cycle `done` pulse. No condition write from a later element ever reaches the condition file.

Top module: `ddff_seq`

## Requirements
- R1: After `start` with a length N of 1 or more and no failing element, elements 0 to N-1 are processed one per clock in ascending order. `done` pulses in the (N+1)th cycle after the start edge, and `vl_out` equals N.
- R2: The read address is `src_base` plus the element index when `src_vec`=1. It is `src_base` for every element when `src_vec`=0. Addresses wrap modulo the register count.
- R3: The condition write address is `dst_base` plus the element index when `dst_vec`=1. It is `dst_base` for every element when `dst_vec`=0, and it also wraps.
- R4: The condition value holds three bits. Bit 2 is set when the signed read value is less than the sign-extended immediate, bit 1 when it is greater, and bit 0 when it is equal.
- R5: `test_sel` picks the tested bit: 0 picks bit 0, 1 picks bit 1, 2 picks bit 2, and 3 picks a constant zero. With `fail_if_set`=1 an element fails when the tested bit is 1. With `fail_if_set`=0 it fails when the bit is 0.
- R6: With `incl_mode`=1, a failure at element i writes that element's condition and sets `vl_out` to i+1.
- R7: With `incl_mode`=0, a failure at element i does not write that element's condition and sets `vl_out` to i. This gives 0 when element 0 fails.
- R8: After a failure at element i, no element above i is written, and `done` pulses in the (i+2)th cycle after the start edge.
- R9: A `start` with length 0 pulses `done` in the next cycle with no condition write, and `vl_out` becomes 0.
- R10: A `start` during a run is ignored. `vl_out` holds its value between completions.
- R11: After reset, `done` and `cr_we` are 0 and `vl_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run, taken only when idle |
| vl_in | input | VLW (7) | Requested vector length |
| incl_mode | input | 1 | 1 keeps the failing element, 0 drops it |
| src_vec | input | 1 | Source operand is vectorised |
| dst_vec | input | 1 | Destination condition operand is vectorised |
| src_base | input | RAW (7) | First source register slot |
| dst_base | input | CAW (7) | First condition-field slot |
| imm | input | 16 | Signed immediate |
| test_sel | input | 2 | Tested condition bit |
| fail_if_set | input | 1 | Test sense |
| rd_addr | output | RAW (7) | Register read address |
| rd_data | input | XLEN (32) | Register read data, same cycle as the address |
| cr_we | output | 1 | Condition write enable |
| cr_addr | output | CAW (7) | Condition write slot |
| cr_val | output | 3 | Condition value |
| vl_out | output | VLW (7) | Resulting vector length |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `rd_data` is a combinational function of `rd_addr` settled within the same cycle. They also take for granted that the configuration inputs matter only on the accepted start edge, because the block latches them there. The bench serves reads from its own register array through a continuous assignment. It changes inputs only at falling edges. One scenario deliberately pulses `start` mid-run with a different length, to confirm that the latched configuration alone governs the run.

// File: rtl/ddff_pkg.sv
package ddff_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_st_t;
  localparam int unsigned CND_LT = 2;
  localparam int unsigned CND_GT = 1;
  localparam int unsigned CND_EQ = 0;
  typedef logic [2:0] cnd_t;
endpackage

// File: rtl/ddff_cmp.sv
module ddff_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   opnd,
  input  logic [15:0]       imm,
  input  logic [1:0]        sel,
  input  logic              fail_if_set,
  output ddff_pkg::cnd_t    cnd,
  output logic              fail
);
  logic signed [XLEN-1:0] a_s;
  logic signed [XLEN-1:0] b_s;
  logic                   tbit;

  always_comb begin
    a_s = opnd;
    b_s = {{(XLEN-16){imm[15]}}, imm};
    cnd = '0;
    cnd[ddff_pkg::CND_LT] = (a_s < b_s);
    cnd[ddff_pkg::CND_GT] = (a_s > b_s);
    cnd[ddff_pkg::CND_EQ] = (a_s == b_s);
    tbit = (sel == 2'd3) ? 1'b0 : cnd[sel];
    fail = fail_if_set ? tbit : ~tbit;
  end
endmodule

// File: rtl/ddff_offs.sv
module ddff_offs #(
  parameter int unsigned AW  = 7,
  parameter int unsigned VLW = 7
) (
  input  logic [AW-1:0]  base,
  input  logic           vec,
  input  logic [VLW-1:0] idx,
  output logic [AW-1:0]  addr
);
  localparam int unsigned XW = (AW > VLW) ? AW : VLW;
  logic [XW-1:0] step;

  always_comb begin
    step = vec ? XW'(idx) : '0;
    addr = base + AW'(step);
  end
endmodule

// File: rtl/ddff_seq.sv
module ddff_seq #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLW  = 7,
  parameter int unsigned RAW  = 7,
  parameter int unsigned CAW  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl_in,
  input  logic             incl_mode,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic [RAW-1:0]   src_base,
  input  logic [CAW-1:0]   dst_base,
  input  logic [15:0]      imm,
  input  logic [1:0]       test_sel,
  input  logic             fail_if_set,
  output logic [RAW-1:0]   rd_addr,
  input  logic [XLEN-1:0]  rd_data,
  output logic             cr_we,
  output logic [CAW-1:0]   cr_addr,
  output logic [2:0]       cr_val,
  output logic [VLW-1:0]   vl_out,
  output logic             done
);
  import ddff_pkg::*;

  localparam logic [VLW-1:0] ONE = VLW'(1);

  seq_st_t         st_q, st_d;
  logic [VLW-1:0]  idx_q, idx_d;
  logic [VLW-1:0]  vl_q, vl_out_d;
  logic            incl_q, svec_q, dvec_q, sense_q;
  logic [RAW-1:0]  sbase_q;
  logic [CAW-1:0]  dbase_q;
  logic [15:0]     imm_q;
  logic [1:0]      sel_q;
  logic            done_d;
  logic            accept, running, last, finish;
  logic            el_fail;
  cnd_t            el_cnd;

  ddff_offs #(.AW(RAW), .VLW(VLW)) i_src_offs (
    .base(sbase_q), .vec(svec_q), .idx(idx_q), .addr(rd_addr)
  );

  ddff_offs #(.AW(CAW), .VLW(VLW)) i_dst_offs (
    .base(dbase_q), .vec(dvec_q), .idx(idx_q), .addr(cr_addr)
  );

  ddff_cmp #(.XLEN(XLEN)) i_cmp (
    .opnd(rd_data), .imm(imm_q), .sel(sel_q), .fail_if_set(sense_q),
    .cnd(el_cnd), .fail(el_fail)
  );

  // Next-state logic
  always_comb begin
    accept   = (st_q == ST_IDLE) && start;
    running  = (st_q == ST_RUN);
    last     = (idx_q == (vl_q - ONE));
    finish   = running && (el_fail || last);
    cr_we    = running && (!el_fail || incl_q);
    cr_val   = el_cnd;
    st_d     = st_q;
    idx_d    = idx_q;
    vl_out_d = vl_out;
    done_d   = 1'b0;
    if (accept) begin
      idx_d = '0;
      if (vl_in == '0) begin
        done_d   = 1'b1;
        vl_out_d = '0;
      end else begin
        st_d = ST_RUN;
      end
    end else if (running) begin
      idx_d = idx_q + ONE;
      if (finish) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        if (el_fail) vl_out_d = incl_q ? (idx_q + ONE) : idx_q;
        else         vl_out_d = vl_q;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      vl_out <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      vl_out <= vl_out_d;
      done   <= done_d;
    end
  end

  // Configuration latched on accept (clock enable)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      incl_q  <= 1'b0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      sense_q <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
      imm_q   <= '0;
      sel_q   <= '0;
    end else if (accept) begin
      vl_q    <= vl_in;
      incl_q  <= incl_mode;
      svec_q  <= src_vec;
      dvec_q  <= dst_vec;
      sense_q <= fail_if_set;
      sbase_q <= src_base;
      dbase_q <= dst_base;
      imm_q   <= imm;
      sel_q   <= test_sel;
    end
  end

  // Assertions
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (idx_q < vl_q));

  a_r8_no_write_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cr_we);

  a_r7_trunc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= vl_q));

  a_r10_vl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vl_out) |-> done);

  a_r2_scalar_src: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !svec_q) |-> $stable(rd_addr));

  a_r3_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && $past(cr_we) && dvec_q) |-> (cr_addr == CAW'($past(cr_addr) + 1'b1)));
endmodule

// File: tb/test_ddff_seq.sv
module test_ddff_seq;
  localparam int unsigned XLEN = 32;
  localparam int unsigned VLW  = 7;
  localparam int unsigned RAW  = 7;
  localparam int unsigned CAW  = 7;
  localparam int unsigned NREG = 1 << RAW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [VLW-1:0]  vl_in;
  logic            incl_mode, src_vec, dst_vec, fail_if_set;
  logic [RAW-1:0]  src_base, rd_addr;
  logic [CAW-1:0]  dst_base, cr_addr;
  logic [15:0]     imm;
  logic [1:0]      test_sel;
  logic [XLEN-1:0] rd_data;
  logic            cr_we, done;
  logic [2:0]      cr_val;
  logic [VLW-1:0]  vl_out;

  logic [XLEN-1:0] rf [NREG];
  int nchk = 0;
  int nerr = 0;
  int cyc_total = 0;

  logic [CAW-1:0] w_addr [200];
  logic [2:0]     w_val  [200];
  int             nw;

  assign rd_data = rf[rd_addr];

  always #2 clk = ~clk;

  ddff_seq #(.XLEN(XLEN), .VLW(VLW), .RAW(RAW), .CAW(CAW)) i_ddff_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .incl_mode(incl_mode),
    .src_vec(src_vec), .dst_vec(dst_vec), .src_base(src_base), .dst_base(dst_base),
    .imm(imm), .test_sel(test_sel), .fail_if_set(fail_if_set), .rd_addr(rd_addr),
    .rd_data(rd_data), .cr_we(cr_we), .cr_addr(cr_addr), .cr_val(cr_val),
    .vl_out(vl_out), .done(done)
  );

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 100000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc_total);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (act != exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runs one operation and compares against the requirement-derived model.
  task automatic run_case(input string tag, input int vl, input bit incl, input bit sv,
                          input bit dv, input int sb, input int db, input int im,
                          input int sel, input bit sense, input bit poke);
    int   e_vl, e_lat, e_nw, cyc;
    bit   failed;
    logic [CAW-1:0] e_addr [200];
    logic [2:0]     e_val  [200];
    logic signed [XLEN-1:0] s, iv;
    logic [2:0] c;
    bit tb, fl;
    // expected model
    e_vl = vl; e_nw = 0; failed = 0; e_lat = (vl == 0) ? 1 : vl + 1;
    iv = XLEN'(signed'(16'(im)));
    for (int i = 0; i < vl; i++) begin
      s = rf[(sb + (sv ? i : 0)) % NREG];
      c = {(s < iv), (s > iv), (s == iv)};
      tb = (sel == 3) ? 1'b0 : c[sel];
      fl = sense ? tb : !tb;
      if (!fl || incl) begin
        e_addr[e_nw] = CAW'((db + (dv ? i : 0)) % (1 << CAW));
        e_val[e_nw]  = c;
        e_nw++;
      end
      if (fl) begin
        e_vl = incl ? i + 1 : i;
        e_lat = i + 2;
        failed = 1;
        break;
      end
    end
    // drive
    @(negedge clk);
    vl_in = VLW'(vl); incl_mode = incl; src_vec = sv; dst_vec = dv;
    src_base = RAW'(sb); dst_base = CAW'(db); imm = 16'(im);
    test_sel = 2'(sel); fail_if_set = sense; start = 1'b1;
    @(posedge clk);
    nw = 0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; vl_in = VLW'(3); incl_mode = 0; imm = 16'h7fff; test_sel = 2'd0;
      end else begin
        start = 1'b0;
      end
      if (cr_we) begin
        if (nw < 200) begin w_addr[nw] = cr_addr; w_val[nw] = cr_val; end
        nw++;
      end
      if (done || cyc > 300) break;
    end
    start = 1'b0;
    chk({tag, " done latency"}, cyc, e_lat);
    chk({tag, " vl_out"}, int'(vl_out), e_vl);
    chk({tag, " write count"}, nw, e_nw);
    for (int k = 0; k < e_nw && k < nw; k++) begin
      chk({tag, " write addr"}, int'(w_addr[k]), int'(e_addr[k]));
      chk({tag, " write value"}, int'(w_val[k]), int'(e_val[k]));
    end
    @(negedge clk);
    chk({tag, " done single pulse"}, int'(done), 0);
    chk({tag, " vl_out held after done"}, int'(vl_out), e_vl);
  endtask

  task automatic t_reset();
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset cr_we", int'(cr_we), 0);
    chk("R11 reset vl_out", int'(vl_out), 0);
  endtask

  task automatic t_full_pass();   // R1 R2 R3 R4: LT bit always set, fail if clear
    run_case("R1 R4 full pass", 8, 0, 1, 1, 4, 10, 1000, 2, 0, 0);
  endtask

  task automatic t_scalar_src();  // R2
    run_case("R2 scalar source", 5, 1, 0, 1, 20, 0, -3, 1, 1, 0);
  endtask

  task automatic t_scalar_dst();  // R3 with wrap of source
    run_case("R3 scalar dest", 6, 0, 1, 0, 124, 33, 5000, 2, 0, 0);
  endtask

  task automatic t_incl_fail();   // R6 R8: element 3 equals imm
    rf[40] = 7; rf[41] = 8; rf[42] = 9; rf[43] = 77; rf[44] = 77;
    run_case("R6 R8 inclusive fail", 5, 1, 1, 1, 40, 120, 77, 0, 1, 0);
  endtask

  task automatic t_excl_fail();   // R7 R8: same data, exclusive
    run_case("R7 R8 exclusive fail", 5, 0, 1, 1, 40, 120, 77, 0, 1, 0);
  endtask

  task automatic t_excl_zero();   // R7: element 0 fails
    rf[50] = 32'hffff_fff0;       // -16 > -20, GT set
    run_case("R7 exclusive to zero", 4, 0, 1, 1, 50, 2, -20, 1, 1, 0);
  endtask

  task automatic t_vl0();         // R9
    run_case("R9 zero length", 0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_start();  // R10
    run_case("R10 start while busy", 9, 1, 1, 1, 60, 90, 30000, 2, 0, 1);
  endtask

  task automatic t_sel3();        // R5: constant zero never fails with sense set
    run_case("R5 select three", 7, 0, 1, 1, 70, 70, 0, 3, 1, 0);
    run_case("R5 select three clear", 7, 1, 1, 1, 70, 70, 0, 3, 0, 0);
  endtask

  task automatic t_signed();      // R4 R5: negative data versus negative imm
    rf[100] = -5; rf[101] = -1; rf[102] = -9; rf[103] = -10; rf[104] = 3;
    run_case("R4 signed lt", 5, 1, 1, 1, 100, 100, -8, 2, 1, 0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = XLEN'((i * 37) % 101 - 50);
    rst_n = 1'b0; start = 1'b0; vl_in = '0; incl_mode = 0; src_vec = 0; dst_vec = 0;
    src_base = '0; dst_base = '0; imm = '0; test_sel = '0; fail_if_set = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_pass();
    t_scalar_src();
    t_scalar_dst();
    t_incl_fail();
    t_excl_fail();
    t_excl_zero();
    t_vl0();
    t_busy_start();
    t_sel3();
    t_signed();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule